// File: doc/BRIEF.md
# Systolic Small-Radix DFT Processing Row

This block evaluates short discrete Fourier transforms as matrix-vector products, Y = C·X. C is a b×b coefficient matrix and b, the radix, is any value from 2 to 6. One physical row of six processing elements (PEs) stands in for a full b×b systolic array. Before a run, software-side logic writes the coefficient matrix into per-PE registers through a load port. PE k holds row k of C.

Complex samples then arrive on a valid-qualified stream, in groups of b. Each sample enters PE 0 and moves one PE further along the row on every clock edge. PE k multiplies each sample it sees by its coefficient C[k][n] and adds the product into an accumulator. When the last sample of the group passes, PE k rounds the total to sample width and stores it in its own dual-port RAM, at the current group address. PEs with an index of b or higher stay idle.

A one-cycle done pulse marks the end of a group. A shared read port returns any stored result, one cycle after the request.

Top module: `dft_row`

## Requirements
- R1: After reset, `done_o` is 0. While `rd_pe_i` selects no PE, `rd_re_o` and `rd_im_o` are 0.
- R2: A cycle with `cf_we_i` high stores (`cf_re_i`, `cf_im_i`) as coefficient C[`cf_row_i`][`cf_col_i`]. Coefficients are signed fixed point with CW-1 fraction bits. A load whose row or column is 6 or 7 changes no coefficient.
- R3: For each group, PE k (k < b) stores y[k] = Σn C[k][n]·x[n], using complex arithmetic. The real part is stored in bits [2·DW-1:DW] of the RAM word and the imaginary part in bits [DW-1:0]. Sample n of a group is the n-th accepted sample, counting from 0.
- R4: Before it is stored, each part of the sum s is rounded half up, as (s + 2^(CW-2)) >> (CW-1) with an arithmetic shift. The result is then saturated to [-2^(DW-1), 2^(DW-1)-1].
- R5: PE k writes on the k-th clock edge after the edge that accepts the last sample of a group. `done_o` is high for the single cycle after the edge on which PE b-1 writes.
- R6: PEs with an index of b or higher leave their RAM unchanged.
- R7: A requested radix below 2 acts as 2, and a requested radix above 6 acts as 6.
- R8: The radix is sampled together with the first sample of each group. Changing `radix_i` later in the group has no effect on that group.
- R9: The group address is 0 after reset. It rises by one after every group and wraps modulo 2^AW.
- R10: A cycle with `in_valid_i` low is ignored whatever its data. A group may have gaps between its samples.
- R11: A read of RAM `rd_pe_i` at `rd_addr_i` shows on `rd_re_o`/`rd_im_o` after the next clock edge. A `rd_pe_i` of 6 or 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| radix_i | input | 3 | Requested radix b |
| in_valid_i | input | 1 | Sample valid |
| in_re_i | input | DW | Sample real part |
| in_im_i | input | DW | Sample imaginary part |
| cf_we_i | input | 1 | Coefficient write strobe |
| cf_row_i | input | 3 | Coefficient row (PE index) |
| cf_col_i | input | 3 | Coefficient column (sample index) |
| cf_re_i | input | CW | Coefficient real part |
| cf_im_i | input | CW | Coefficient imaginary part |
| rd_pe_i | input | 3 | RAM select for readback |
| rd_addr_i | input | AW | Readback address |
| rd_re_o | output | DW | Read data, real part |
| rd_im_o | output | DW | Read data, imaginary part |
| done_o | output | 1 | Group complete pulse |

## Verification
Call E the edge that accepts the last sample of a group. The bench counts edges from E. After each of edges E through E+b-2 it expects `done_o` low. After edge E+b-1 it expects `done_o` high, and after edge E+b low again.

Stored results are read only after the done pulse, when every active PE has written. Each read request is driven on a falling edge. The data is sampled on the next falling edge, after the one rising edge the read takes.

Inputs change only on falling edges. All compared values come from a model of the coefficients and RAM contents that the bench keeps for itself.

// File: rtl/dft_row_pkg.sv
package dft_row_pkg;
  localparam int RADIX_MIN = 2;
  localparam int RADIX_MAX = 6;

  // Control travelling with each sample along the row
  typedef struct packed {
    logic       vld;
    logic       last;
    logic [2:0] idx;
    logic [2:0] radix;
  } tag_t;

  function automatic logic [2:0] clamp_radix(input logic [2:0] r);
    if (r < 3'(RADIX_MIN)) return 3'(RADIX_MIN);
    if (r > 3'(RADIX_MAX)) return 3'(RADIX_MAX);
    return r;
  endfunction
endpackage

// File: rtl/dft_row_feed.sv
module dft_row_feed
  import dft_row_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid_i,
  input  logic [2:0]    radix_i,
  output tag_t          tag_o,
  output logic [AW-1:0] addr_o
);
  logic [2:0]    cnt;
  logic [2:0]    grp_radix;
  logic [AW-1:0] grp_addr;
  logic [2:0]    r_eff;
  logic          is_last;

  always_comb begin
    r_eff   = (cnt == 3'd0) ? clamp_radix(radix_i) : grp_radix;
    is_last = (cnt == r_eff - 3'd1);
    tag_o.vld   = in_valid_i;
    tag_o.last  = is_last;
    tag_o.idx   = cnt;
    tag_o.radix = r_eff;
    addr_o      = grp_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      grp_radix <= 3'(RADIX_MIN);
      grp_addr  <= '0;
    end else if (in_valid_i) begin
      if (cnt == 3'd0) grp_radix <= r_eff;
      if (is_last) begin
        cnt      <= '0;
        grp_addr <= grp_addr + 1'b1;
      end else begin
        cnt <= cnt + 3'd1;
      end
    end
  end

  p_radix_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_radix >= 3'(RADIX_MIN)) && (grp_radix <= 3'(RADIX_MAX)));

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 3'd0) |-> (cnt < grp_radix));

  p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && is_last) |=> (grp_addr == AW'($past(grp_addr) + 1'b1)));
endmodule

// File: rtl/dft_row_pe.sv
module dft_row_pe
  import dft_row_pkg::*;
#(
  parameter int K  = 0,
  parameter int DW = 12,
  parameter int CW = 12,
  parameter int AW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cf_we_i,
  input  logic [2:0]           cf_row_i,
  input  logic [2:0]           cf_col_i,
  input  logic signed [CW-1:0] cf_re_i,
  input  logic signed [CW-1:0] cf_im_i,
  input  tag_t                 tag_i,
  input  logic signed [DW-1:0] x_re_i,
  input  logic signed [DW-1:0] x_im_i,
  input  logic [AW-1:0]        addr_i,
  output logic                 we_o,
  output logic                 fin_o,
  output logic [AW-1:0]        waddr_o,
  output logic [2*DW-1:0]      wdata_o
);
  localparam int NPE  = RADIX_MAX;
  localparam int ACCW = DW + CW + 1 + $clog2(RADIX_MAX);
  localparam logic signed [ACCW:0] HALF = (ACCW+1)'(1) << (CW-2);
  localparam logic signed [ACCW:0] TOPV = (ACCW+1)'((1 << (DW-1)) - 1);
  localparam logic signed [ACCW:0] BOTV = -TOPV - (ACCW+1)'(1);

  function automatic logic signed [ACCW-1:0] mul_re(
    input logic signed [DW-1:0] ar, input logic signed [DW-1:0] ai,
    input logic signed [CW-1:0] br, input logic signed [CW-1:0] bi);
    logic signed [DW+CW-1:0] p, q;
    p = ar * br;
    q = ai * bi;
    return ACCW'(p) - ACCW'(q);
  endfunction

  function automatic logic signed [ACCW-1:0] mul_im(
    input logic signed [DW-1:0] ar, input logic signed [DW-1:0] ai,
    input logic signed [CW-1:0] br, input logic signed [CW-1:0] bi);
    logic signed [DW+CW-1:0] p, q;
    p = ar * bi;
    q = ai * br;
    return ACCW'(p) + ACCW'(q);
  endfunction

  function automatic logic [DW-1:0] rnd_sat(input logic signed [ACCW-1:0] s);
    logic signed [ACCW:0] t;
    t = ($signed({s[ACCW-1], s}) + HALF) >>> (CW-1);
    if (t > TOPV) return TOPV[DW-1:0];
    if (t < BOTV) return BOTV[DW-1:0];
    return t[DW-1:0];
  endfunction

  logic signed [CW-1:0]   c_re [NPE];
  logic signed [CW-1:0]   c_im [NPE];
  logic signed [ACCW-1:0] acc_re, acc_im;
  logic signed [ACCW-1:0] sum_re, sum_im;
  logic signed [CW-1:0]   k_re, k_im;
  logic [2:0]             sel;
  logic                   act;

  // Coefficient registers for row K
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NPE; n++) begin
        c_re[n] <= '0;
        c_im[n] <= '0;
      end
    end else if (cf_we_i && (cf_row_i == 3'(K)) && (cf_col_i < 3'(NPE))) begin
      c_re[cf_col_i] <= cf_re_i;
      c_im[cf_col_i] <= cf_im_i;
    end
  end

  always_comb begin
    act  = tag_i.vld && (int'(tag_i.radix) > K);
    sel  = (tag_i.idx < 3'(NPE)) ? tag_i.idx : 3'd0;
    k_re = c_re[sel];
    k_im = c_im[sel];
    sum_re = ((tag_i.idx == 3'd0) ? '0 : acc_re) + mul_re(x_re_i, x_im_i, k_re, k_im);
    sum_im = ((tag_i.idx == 3'd0) ? '0 : acc_im) + mul_im(x_re_i, x_im_i, k_re, k_im);
    we_o    = act && tag_i.last;
    fin_o   = we_o && (int'(tag_i.radix) == K + 1);
    waddr_o = addr_i;
    wdata_o = {rnd_sat(sum_re), rnd_sat(sum_im)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_re <= '0;
      acc_im <= '0;
    end else if (act) begin
      acc_re <= sum_re;
      acc_im <= sum_im;
    end
  end
endmodule

// File: rtl/dft_row_ram.sv
module dft_row_ram #(
  parameter int W  = 24,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/dft_row.sv
module dft_row
  import dft_row_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = 12,
  parameter int AW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           radix_i,
  input  logic                 in_valid_i,
  input  logic signed [DW-1:0] in_re_i,
  input  logic signed [DW-1:0] in_im_i,
  input  logic                 cf_we_i,
  input  logic [2:0]           cf_row_i,
  input  logic [2:0]           cf_col_i,
  input  logic signed [CW-1:0] cf_re_i,
  input  logic signed [CW-1:0] cf_im_i,
  input  logic [2:0]           rd_pe_i,
  input  logic [AW-1:0]        rd_addr_i,
  output logic signed [DW-1:0] rd_re_o,
  output logic signed [DW-1:0] rd_im_o,
  output logic                 done_o
);
  localparam int NPE = RADIX_MAX;
  localparam int RW  = 2 * DW;

  tag_t                 f_tag;
  logic [AW-1:0]        f_addr;
  tag_t                 s_tag  [NPE-1];
  logic signed [DW-1:0] s_re   [NPE-1];
  logic signed [DW-1:0] s_im   [NPE-1];
  logic [AW-1:0]        s_addr [NPE-1];
  logic [NPE-1:0]       pe_we;
  logic [NPE-1:0]       pe_fin;
  logic [RW-1:0]        rd_w   [NPE];
  logic [2:0]           sel_q;
  logic                 done_q;

  dft_row_feed #(.AW(AW)) u_feed (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .radix_i(radix_i),
    .tag_o(f_tag), .addr_o(f_addr)
  );

  // Nearest-neighbour sample pipeline between PEs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPE-1; i++) begin
        s_tag[i]  <= '0;
        s_re[i]   <= '0;
        s_im[i]   <= '0;
        s_addr[i] <= '0;
      end
    end else begin
      s_tag[0]  <= f_tag;
      s_re[0]   <= in_re_i;
      s_im[0]   <= in_im_i;
      s_addr[0] <= f_addr;
      for (int i = 1; i < NPE-1; i++) begin
        s_tag[i]  <= s_tag[i-1];
        s_re[i]   <= s_re[i-1];
        s_im[i]   <= s_im[i-1];
        s_addr[i] <= s_addr[i-1];
      end
    end
  end

  for (genvar k = 0; k < NPE; k++) begin : g_pe
    tag_t                 t_in;
    logic signed [DW-1:0] r_in, i_in;
    logic [AW-1:0]        a_in;
    logic [AW-1:0]        w_addr;
    logic [RW-1:0]        w_data;

    if (k == 0) begin : g_head
      assign t_in = f_tag;
      assign r_in = in_re_i;
      assign i_in = in_im_i;
      assign a_in = f_addr;
    end else begin : g_link
      assign t_in = s_tag[k-1];
      assign r_in = s_re[k-1];
      assign i_in = s_im[k-1];
      assign a_in = s_addr[k-1];
    end

    dft_row_pe #(.K(k), .DW(DW), .CW(CW), .AW(AW)) u_pe (
      .clk(clk), .rst_n(rst_n),
      .cf_we_i(cf_we_i), .cf_row_i(cf_row_i), .cf_col_i(cf_col_i),
      .cf_re_i(cf_re_i), .cf_im_i(cf_im_i),
      .tag_i(t_in), .x_re_i(r_in), .x_im_i(i_in), .addr_i(a_in),
      .we_o(pe_we[k]), .fin_o(pe_fin[k]), .waddr_o(w_addr), .wdata_o(w_data)
    );

    dft_row_ram #(.W(RW), .AW(AW)) u_ram (
      .clk(clk), .rst_n(rst_n), .we_i(pe_we[k]), .waddr_i(w_addr),
      .wdata_i(w_data), .raddr_i(rd_addr_i), .rdata_o(rd_w[k])
    );

    if (k > 0) begin : g_chk
      p_wr_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pe_we[k] |-> $past(pe_we[k-1]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 3'(NPE);
      done_q <= 1'b0;
    end else begin
      sel_q  <= rd_pe_i;
      done_q <= |pe_fin;
    end
  end

  always_comb begin
    {rd_re_o, rd_im_o} = '0;
    for (int i = 0; i < NPE; i++) begin
      if (sel_q == 3'(i)) {rd_re_o, rd_im_o} = rd_w[i];
    end
  end

  assign done_o = done_q;

  p_done_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(|pe_we));
endmodule

// File: tb/tb_dft_row.sv
module tb_dft_row;
  localparam int DW = 12, CW = 12, AW = 4, NP = 6, DEPTH = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, in_valid, cf_we, done;
  logic [2:0] radix, cf_row, cf_col, rd_pe;
  logic signed [DW-1:0] in_re, in_im, rd_re, rd_im;
  logic signed [CW-1:0] cf_re, cf_im;
  logic [AW-1:0] rd_addr;

  dft_row #(.DW(DW), .CW(CW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .radix_i(radix), .in_valid_i(in_valid),
    .in_re_i(in_re), .in_im_i(in_im), .cf_we_i(cf_we), .cf_row_i(cf_row),
    .cf_col_i(cf_col), .cf_re_i(cf_re), .cf_im_i(cf_im), .rd_pe_i(rd_pe),
    .rd_addr_i(rd_addr), .rd_re_o(rd_re), .rd_im_o(rd_im), .done_o(done)
  );

  int n_chk = 0, n_err = 0;
  int bc_re [NP][NP];
  int bc_im [NP][NP];
  int em_re [NP][DEPTH];
  int em_im [NP][DEPTH];
  bit ew    [NP][DEPTH];
  int ga = 0;
  int xr [NP];
  int xi [NP];

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rsat(longint s);
    longint t;
    t = (s + (64'sd1 <<< (CW-2))) >>> (CW-1);
    if (t > (2**(DW-1) - 1)) return 2**(DW-1) - 1;
    if (t < -(2**(DW-1))) return -(2**(DW-1));
    return int'(t);
  endfunction

  function automatic int eff_radix(int r);
    return (r < 2) ? 2 : ((r > 6) ? 6 : r);
  endfunction

  task automatic load_cf(int row, int col, int re, int im);
    @(negedge clk);
    cf_we = 1'b1; cf_row = 3'(row); cf_col = 3'(col);
    cf_re = CW'(re); cf_im = CW'(im);
    @(negedge clk);
    cf_we = 1'b0;
    if (row < NP && col < NP) begin   // R2: rows/cols 6,7 ignored
      bc_re[row][col] = re;
      bc_im[row][col] = im;
    end
  endtask

  task automatic load_dft(int b);
    for (int k = 0; k < b; k++)
      for (int n = 0; n < b; n++) begin
        real th = 2.0 * 3.14159265358979 * k * n / b;
        real vr = 2047.0 * $cos(th);
        real vi = -2047.0 * $sin(th);
        load_cf(k, n, $rtoi(vr + (vr >= 0.0 ? 0.5 : -0.5)),
                      $rtoi(vi + (vi >= 0.0 ? 0.5 : -0.5)));
      end
  endtask

  // Sends one group; checks done timing (R5) and updates the RAM model.
  task automatic run_group(int r_first, int r_rest, bit gaps);
    int b = eff_radix(r_first);
    for (int n = 0; n < b; n++) begin
      @(negedge clk);
      in_valid = 1'b1; in_re = DW'(xr[n]); in_im = DW'(xi[n]);
      radix = (n == 0) ? 3'(r_first) : 3'(r_rest);
      if (gaps && n < b - 1) begin
        @(negedge clk);
        in_valid = 1'b0; in_re = 12'h5A5; in_im = 12'hA5A;   // R10 junk
        radix = 3'(r_rest);
      end
    end
    for (int k = 0; k < b; k++) begin
      longint sr = 0, si = 0;
      for (int n = 0; n < b; n++) begin
        sr += longint'(xr[n]) * bc_re[k][n] - longint'(xi[n]) * bc_im[k][n];
        si += longint'(xr[n]) * bc_im[k][n] + longint'(xi[n]) * bc_re[k][n];
      end
      em_re[k][ga] = rsat(sr);
      em_im[k][ga] = rsat(si);
      ew[k][ga] = 1'b1;
    end
    ga = (ga + 1) % DEPTH;
    for (int j = 0; j < b; j++) begin
      @(negedge clk);
      in_valid = 1'b0;
      chk("R5", $sformatf("done after edge E+%0d", j), int'(done), (j == b - 1) ? 1 : 0);
    end
    @(negedge clk);
    chk("R5", "done after edge E+b", int'(done), 0);
  endtask

  task automatic rd(int pe, int a, output int re, output int im);
    @(negedge clk);
    rd_pe = 3'(pe); rd_addr = AW'(a);
    @(negedge clk);
    re = rd_re; im = rd_im;
  endtask

  task automatic check_addr(int a, string req);
    for (int k = 0; k < NP; k++) begin
      if (ew[k][a]) begin
        int vr, vi;
        rd(k, a, vr, vi);
        chk(req, $sformatf("PE%0d addr %0d re", k, a), vr, em_re[k][a]);
        chk(req, $sformatf("PE%0d addr %0d im", k, a), vi, em_im[k][a]);
      end
    end
  endtask

  task automatic set_pattern(int g);
    for (int n = 0; n < NP; n++) begin
      xr[n] = ((g * 37 + n * 113) % 4001) - 2000;
      xi[n] = ((g * 91 + n * 57 + 11) % 3901) - 1950;
    end
    if (g == 3) for (int n = 0; n < NP; n++) begin xr[n] = 2047; xi[n] = -2048; end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; radix = 3'd6; in_re = '0; in_im = '0;
    cf_we = 1'b0; cf_row = '0; cf_col = '0; cf_re = '0; cf_im = '0;
    rd_pe = 3'd7; rd_addr = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "rd_re idle", int'(rd_re), 0);
    chk("R1", "rd_im idle", int'(rd_im), 0);
  endtask

  task automatic t_fill_wrap;   // R3, R9: 16 radix-6 groups, addresses 0..15
    load_dft(6);
    for (int g = 0; g < DEPTH; g++) begin
      set_pattern(g);
      run_group(6, 6, 1'b0);
      check_addr(g, "R3");
    end
  endtask

  task automatic t_small_radix;  // R6, R9: radix 2 wraps to addr 0
    load_dft(2);
    set_pattern(20);
    run_group(2, 2, 1'b0);
    check_addr(0, "R6");
    for (int b = 3; b <= 5; b++) begin
      load_dft(b);
      set_pattern(20 + b);
      run_group(b, b, 1'b0);
      check_addr(b - 2, "R3");
    end
  endtask

  task automatic t_clamp;        // R7
    load_dft(2);
    set_pattern(30);
    run_group(1, 1, 1'b0);
    check_addr(4, "R7");
    load_dft(6);
    set_pattern(31);
    run_group(7, 7, 1'b0);
    check_addr(5, "R7");
  endtask

  task automatic t_mid_change;   // R8
    set_pattern(40);
    run_group(6, 2, 1'b0);
    check_addr(6, "R8");
    set_pattern(41);
    run_group(3, 6, 1'b0);
    check_addr(7, "R8");
  endtask

  task automatic t_gaps;         // R10
    load_dft(4);
    set_pattern(50);
    run_group(4, 4, 1'b1);
    check_addr(8, "R10");
  endtask

  task automatic t_round_sat;    // R4
    int vr, vi;
    load_cf(0, 0, 1024, 0);
    load_cf(0, 1, 0, 0);
    xr[0] = 1; xi[0] = 0; xr[1] = 5; xi[1] = 5;
    run_group(2, 2, 1'b0);
    rd(0, 9, vr, vi);
    chk("R4", "half rounds up re", vr, 1);
    chk("R4", "zero im", vi, 0);
    xr[0] = -1; xi[0] = 3;
    run_group(2, 2, 1'b0);
    rd(0, 10, vr, vi);
    chk("R4", "negative half re", vr, 0);
    chk("R4", "1.5 rounds up im", vi, 2);
    check_addr(10, "R4");
    for (int n = 0; n < NP; n++) begin
      load_cf(0, n, 2047, 0);
      xr[n] = 2047; xi[n] = -2048;
    end
    run_group(6, 6, 1'b0);
    rd(0, 11, vr, vi);
    chk("R4", "positive saturation", vr, 2047);
    chk("R4", "negative saturation", vi, -2048);
  endtask

  task automatic t_ignored_load; // R2
    load_dft(6);
    load_cf(6, 0, 5, 5);
    load_cf(7, 1, 7, 7);
    load_cf(0, 6, 9, 9);
    load_cf(1, 7, 3, 3);
    set_pattern(60);
    run_group(6, 6, 1'b0);
    check_addr(12, "R2");
  endtask

  task automatic t_read_sel;     // R11
    int vr, vi;
    rd(6, 0, vr, vi);
    chk("R11", "pe6 re", vr, 0);
    chk("R11", "pe6 im", vi, 0);
    rd(7, 3, vr, vi);
    chk("R11", "pe7 re", vr, 0);
    check_addr(3, "R11");
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_wrap();
    t_small_radix();
    t_clamp();
    t_mid_change();
    t_gaps();
    t_round_sat();
    t_ignored_load();
    t_read_sel();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule